// File: doc/BRIEF.md
# Cacheable Window Control Register Bank

This block is the software-visible control and status bank of a flash instruction-cache controller. Software programs a cacheable address window with a lower and an upper bound, and sets the cache enable and RAM enable bits. It can also set a RAM segment base. The bank compares every fetch address from the cache core against the window and reports whether that fetch may be served from the cache.

The bank watches write traffic on the bus. A write that lands inside the window while caching is enabled could leave the cache incoherent, so it raises a write-hit flag. A write error reported by the cache data memory raises a second flag. While either flag is set, the cache counts as logically disabled and no fetch is reported cacheable. Hit and miss strobes from the core drive two 32-bit event counters. A status bit shows when the tag memory has finished initialising.

Register offsets (byte address on `reg_addr`): 0x00 identifier, 0x04 control, 0x08 status, 0x0C low bound, 0x10 high bound, 0x14 RAM segment, 0x18 hit counter, 0x1C miss counter, 0x20 error flags. Reads return data combinationally in the same cycle. A write takes effect at the clock edge on which `reg_we` is high.

Top module: `fetch_window_regs`

## Requirements
- R1: After reset, every register reads zero, except offset 0x00, which always returns the parameter `ID_VALUE`. Writes to offsets 0x00 and 0x08 are ignored.
- R2: In the control register, bit 31 is the cache enable and bit 30 is the RAM enable. Bits 29:0 always read zero.
- R3: The low bound register keeps write data bits 31:12 and the high bound register keeps write data bits 31:12. Bits 11:0 of both read zero. The effective low bound is {low[31:12], 12'h000} and the effective high bound is {high[31:12], 12'hFFF}.
- R4: `fetch_cacheable` is 1 exactly when `fetch_addr` lies inside the effective low and high bounds, both ends included, the cache enable is set, and both error flags are 0.
- R5: A write to either bound register is ignored while the cache enable bit is 1.
- R6: The RAM segment register keeps write data bits 31:15 and reads zero in bits 14:0. A write to it is ignored while the RAM enable bit is 1.
- R7: The hit counter (0x18) increments by one in each cycle with `hit_pulse` high. The miss counter (0x1C) increments in the same way on `miss_pulse`.
- R8: Writing zero to a counter clears it, even when an event arrives in the same cycle. Writing a nonzero value is ignored.
- R9: Status bit 31 equals `init_done`. Status bits 30:0 read zero.
- R10: Error flag bit 1 (write-hit) is set one cycle after `wr_obs_valid` is seen with `wr_obs_addr` inside the window while the cache enable is 1. Flag bit 0 (write-error) is set one cycle after `ram_wr_err`. Writing 1 to a flag bit clears it, writing 0 has no effect, and a set event in the same cycle wins over the clear.
- R11: `cache_active` is 1 exactly when the cache enable is 1 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_addr | input | 32 | Fetch address from the cache core |
| fetch_cacheable | output | 1 | Fetch may be served from the cache |
| wr_obs_valid | input | 1 | A bus write was observed |
| wr_obs_addr | input | 32 | Address of the observed write |
| ram_wr_err | input | 1 | Write error from the cache data memory |
| hit_pulse | input | 1 | Cache hit event |
| miss_pulse | input | 1 | Cache miss event |
| init_done | input | 1 | Tag memory initialisation finished |
| cache_active | output | 1 | Cache enabled and no error flag set |

## Verification
The window comparison is driven with addresses one below the low bound, exactly on each bound, one above the high bound, in the middle of the window, at all ones and at zero. These patterns separate an inclusive compare from an exclusive one, and they show whether the high bound is padded with ones instead of zeros. The same addresses are tried again with caching disabled and with an error flag set, so that the gating is told apart from the compare itself. Counter tests place a clearing write on the same cycle as an event and write a nonzero value, which separates clear-on-zero from load-on-write. Lock tests write the bounds and the segment while their enable is set and then read the registers back.

// File: rtl/fetch_window_regs.sv
module fetch_window_regs #(
  parameter int          AW       = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A31_0102
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   fetch_addr,
  output logic          fetch_cacheable,
  input  logic          wr_obs_valid,
  input  logic [31:0]   wr_obs_addr,
  input  logic          ram_wr_err,
  input  logic          hit_pulse,
  input  logic          miss_pulse,
  input  logic          init_done,
  output logic          cache_active
);
  localparam logic [AW-1:0] OFF_ID   = AW'(8'h00);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h04);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h08);
  localparam logic [AW-1:0] OFF_LO   = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_HI   = AW'(8'h10);
  localparam logic [AW-1:0] OFF_SEG  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_HITS = AW'(8'h18);
  localparam logic [AW-1:0] OFF_MISS = AW'(8'h1C);
  localparam logic [AW-1:0] OFF_FLAG = AW'(8'h20);

  logic        en_q, ram_en_q;
  logic [19:0] lo_q, hi_q;
  logic [16:0] seg_q;
  logic [31:0] hits_q, misses_q;
  logic [1:0]  flags_q;

  logic [31:0] lo_base, hi_top;
  assign lo_base = {lo_q, 12'h000};
  assign hi_top  = {hi_q, 12'hFFF};

  logic fetch_in, obs_in;
  assign fetch_in = (fetch_addr >= lo_base) && (fetch_addr <= hi_top);
  assign obs_in   = (wr_obs_addr >= lo_base) && (wr_obs_addr <= hi_top);

  logic wr_ctrl, wr_lo, wr_hi, wr_seg, wr_hits, wr_miss, wr_flag, wzero;
  assign wr_ctrl = reg_we && reg_addr == OFF_CTRL;
  assign wr_lo   = reg_we && reg_addr == OFF_LO  && !en_q;
  assign wr_hi   = reg_we && reg_addr == OFF_HI  && !en_q;
  assign wr_seg  = reg_we && reg_addr == OFF_SEG && !ram_en_q;
  assign wr_hits = reg_we && reg_addr == OFF_HITS;
  assign wr_miss = reg_we && reg_addr == OFF_MISS;
  assign wr_flag = reg_we && reg_addr == OFF_FLAG;
  assign wzero   = reg_wdata == 32'h0;

  logic [1:0] flag_set, flag_clr;
  assign flag_set = {en_q && wr_obs_valid && obs_in, ram_wr_err};
  assign flag_clr = wr_flag ? reg_wdata[1:0] : 2'b00;

  assign cache_active    = en_q && (flags_q == 2'b00);
  assign fetch_cacheable = cache_active && fetch_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ram_en_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      seg_q    <= '0;
      hits_q   <= '0;
      misses_q <= '0;
      flags_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= reg_wdata[31];
        ram_en_q <= reg_wdata[30];
      end
      if (wr_lo)  lo_q  <= reg_wdata[31:12];
      if (wr_hi)  hi_q  <= reg_wdata[31:12];
      if (wr_seg) seg_q <= reg_wdata[31:15];
      if (wr_hits && wzero)  hits_q   <= '0;
      else if (hit_pulse)    hits_q   <= hits_q + 32'd1;
      if (wr_miss && wzero)  misses_q <= '0;
      else if (miss_pulse)   misses_q <= misses_q + 32'd1;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_ID:   reg_rdata = ID_VALUE;
      OFF_CTRL: reg_rdata = {en_q, ram_en_q, 30'h0};
      OFF_STAT: reg_rdata = {init_done, 31'h0};
      OFF_LO:   reg_rdata = lo_base;
      OFF_HI:   reg_rdata = {hi_q, 12'h000};
      OFF_SEG:  reg_rdata = {seg_q, 15'h0};
      OFF_HITS: reg_rdata = hits_q;
      OFF_MISS: reg_rdata = misses_q;
      OFF_FLAG: reg_rdata = {30'h0, flags_q};
      default:  reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/fetch_window_regs_chk.sv
module fetch_window_regs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          hit_pulse,
  input logic          wr_obs_valid,
  input logic [31:0]   wr_obs_addr,
  input logic          fetch_cacheable,
  input logic          cache_active,
  input logic          en_q,
  input logic [19:0]   lo_q,
  input logic [19:0]   hi_q,
  input logic [31:0]   hits_q,
  input logic [1:0]    flags_q
);
  logic hit_wr;
  assign hit_wr = reg_we && reg_addr == AW'(8'h18);

  a_r5_bounds_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (lo_q == $past(lo_q)) && (hi_q == $past(hi_q)));

  a_r7_hit_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pulse && !hit_wr) |=> hits_q == $past(hits_q) + 32'd1);

  a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && reg_wdata == 32'h0) |=> hits_q == 32'h0);

  a_r8_nonzero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && reg_wdata != 32'h0 && !hit_pulse) |=> $stable(hits_q));

  a_r10_write_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_obs_valid && wr_obs_addr >= {lo_q, 12'h000}
          && wr_obs_addr <= {hi_q, 12'hFFF}) |=> flags_q[1]);

  a_r4_flag_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != 2'b00) |-> !fetch_cacheable);

  a_r11_active_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cache_active |-> en_q);
endmodule

bind fetch_window_regs fetch_window_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .hit_pulse(hit_pulse), .wr_obs_valid(wr_obs_valid),
  .wr_obs_addr(wr_obs_addr), .fetch_cacheable(fetch_cacheable),
  .cache_active(cache_active), .en_q(en_q), .lo_q(lo_q), .hi_q(hi_q),
  .hits_q(hits_q), .flags_q(flags_q)
);

// File: tb/sim_fetch_window_regs.sv
module sim_fetch_window_regs;
  localparam logic [31:0] ID = 32'h5A31_0102;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, fetch_addr = 0, wr_obs_addr = 0;
  logic fetch_cacheable, wr_obs_valid = 0, ram_wr_err = 0;
  logic hit_pulse = 0, miss_pulse = 0, init_done = 0, cache_active;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fetch_window_regs #(.AW(8), .ID_VALUE(ID)) u0 (.*);

  localparam int NV = 7;
  localparam logic [32:0] VEC [NV] = '{
    {32'h000F_FFFF, 1'b0}, {32'h0010_0000, 1'b1}, {32'h001F_FFFF, 1'b1},
    {32'h0020_0000, 1'b0}, {32'h0015_4321, 1'b1}, {32'hFFFF_FFFF, 1'b0},
    {32'h0000_0000, 1'b0}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1 id", 8'h00, ID);
    for (int a = 4; a <= 32; a += 4) rd("R1 reset", 8'(a), 32'h0);
    wr(8'h00, 32'h1234_5678); rd("R1 id ro", 8'h00, ID);
    rd("R9 status low", 8'h08, 32'h0);
    init_done = 1; rd("R9 status high", 8'h08, 32'h8000_0000);

    wr(8'h0C, 32'h0010_0ABC); wr(8'h10, 32'h001F_F123);
    rd("R3 lo", 8'h0C, 32'h0010_0000); rd("R3 hi", 8'h10, 32'h001F_F000);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); fetch_addr = VEC[i][32:1]; #1;
      chk("R4 disabled", {31'h0, fetch_cacheable}, 32'h0);
    end
    wr(8'h04, 32'hFFFF_FFFF);
    rd("R2 ctrl", 8'h04, 32'hC000_0000);
    chk("R11 active", {31'h0, cache_active}, 32'h1);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); fetch_addr = VEC[i][32:1]; #1;
      chk("R4 window", {31'h0, fetch_cacheable}, {31'h0, VEC[i][0]});
    end

    wr(8'h0C, 32'h0);  rd("R5 lo locked", 8'h0C, 32'h0010_0000);
    wr(8'h10, 32'h0);  rd("R5 hi locked", 8'h10, 32'h001F_F000);
    wr(8'h14, 32'hFFFF_FFFF); rd("R6 seg locked", 8'h14, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h14, 32'hABCD_EFFF); rd("R6 seg", 8'h14, 32'hABCD_8000);
    wr(8'h04, 32'h8000_0000);

    @(negedge clk); hit_pulse = 1; miss_pulse = 1;
    repeat (3) @(negedge clk); hit_pulse = 0; miss_pulse = 0;
    rd("R7 hits", 8'h18, 32'd3); rd("R7 miss", 8'h1C, 32'd3);
    wr(8'h18, 32'd5); rd("R8 nonzero", 8'h18, 32'd3);
    @(negedge clk); hit_pulse = 1; reg_we = 1; reg_addr = 8'h18; reg_wdata = 0;
    @(negedge clk); hit_pulse = 0; reg_we = 0;
    rd("R8 clear wins", 8'h18, 32'd0);
    wr(8'h1C, 32'd0); rd("R8 miss clear", 8'h1C, 32'd0);

    @(negedge clk); wr_obs_valid = 1; wr_obs_addr = 32'h0030_0000;
    @(negedge clk); wr_obs_valid = 0;
    rd("R10 outside", 8'h20, 32'h0);
    @(negedge clk); wr_obs_valid = 1; wr_obs_addr = 32'h001F_FFFF;
    @(negedge clk); wr_obs_valid = 0;
    rd("R10 write hit", 8'h20, 32'h2);
    chk("R11 inactive", {31'h0, cache_active}, 32'h0);
    fetch_addr = 32'h0015_0000; #1;
    chk("R4 flag gate", {31'h0, fetch_cacheable}, 32'h0);
    wr(8'h20, 32'h0); rd("R10 w0", 8'h20, 32'h2);
    @(negedge clk); ram_wr_err = 1; @(negedge clk); ram_wr_err = 0;
    rd("R10 err", 8'h20, 32'h3);
    @(negedge clk); ram_wr_err = 1; reg_we = 1; reg_addr = 8'h20; reg_wdata = 32'h3;
    @(negedge clk); ram_wr_err = 0; reg_we = 0;
    rd("R10 set wins", 8'h20, 32'h1);
    wr(8'h20, 32'h1); rd("R10 cleared", 8'h20, 32'h0);
    chk("R11 back", {31'h0, cache_active}, 32'h1);
    wr(8'h04, 32'h0);
    @(negedge clk); wr_obs_valid = 1; wr_obs_addr = 32'h0015_0000;
    @(negedge clk); wr_obs_valid = 0;
    rd("R10 disabled", 8'h20, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule